// File: doc/BRIEF.md
# Repeat Sweep ADC Channel Sequencer

This block drives a separate conversion engine through a group of analog input channels, over and over, for as long as a software-controlled run flag stays high. When the flag rises, the block requests a conversion on channel 0. It waits for the engine to report completion and writes the result into that channel's own result register. It then requests the next higher channel. After the highest channel of the selected group it returns to channel 0 with no software action, and it keeps sweeping until the flag is cleared. No completion interrupt exists in this mode. Software polls the result registers at any time through a read port.

The group size can be two, four, six or eight channels, starting at channel 0. In reduced (8-bit) resolution, the converted value occupies the upper bits of each 10-bit result register and the low bits are zero. Clearing the run flag stops the sweep at the next clock. Any conversion in flight is then dropped.

Top module: `sweep_adc_seq`

## Requirements
- R1: After reset the block is idle: `busy_o` and `conv_start_o` are 0, `chan_o` is 0 and every result register reads 0.
- R2: With the block idle and `run_i` high at a clock edge, `conv_start_o` is high during the following cycle with `chan_o` = 0.
- R3: `conv_start_o` is high for exactly one cycle per conversion. The next pulse comes only after `conv_done_i` has been seen high while the block is waiting; done pulses during the launch cycle are ignored.
- R4: When `conv_done_i` is high while waiting and `run_i` is high, the formatted `conv_data_i` is written into the result register whose index equals `chan_o`, and it can be read back on `rd_data_o` by putting that index on `rd_addr_i`.
- R5: `grp_sel_i` encoding: 0 selects channels 0..1, 1 selects 0..3, 2 selects 0..5, 3 selects 0..7. Channels are converted in ascending order.
- R6: After the last channel of the group completes, the next launch is on channel 0. The sweep repeats for as long as `run_i` stays high.
- R7: If `run_i` is low at a clock edge while busy, the block is idle after that edge (`busy_o` 0, `chan_o` 0). A later done for the abandoned conversion writes nothing.
- R8: With `res8_i` = 1 the stored value is `{conv_data_i[9:2], 2'b00}`; with `res8_i` = 0 all 10 bits are stored.
- R9: A read of a register in the same cycle that it is written returns the previous contents. The new value appears in the next cycle.
- R10: `conv_done_i` while idle has no effect: no register changes and no launch occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Software run flag; high sweeps, low stops |
| grp_sel_i | input | 2 | Channel group select (R5 encoding) |
| res8_i | input | 1 | 1 = reduced 8-bit resolution formatting |
| conv_start_o | output | 1 | One-cycle conversion request to the engine |
| conv_done_i | input | 1 | Engine completion strobe |
| conv_data_i | input | 10 | Engine conversion result |
| chan_o | output | 3 | Channel selected for the current conversion |
| busy_o | output | 1 | High while a sweep is active |
| rd_addr_i | input | 3 | Result register read index |
| rd_data_o | output | 10 | Result register read data |

## Verification
A corrupted channel counter is visible at the next `conv_start_o` pulse: the launched channel breaks the ascending, wrapping order expected for the selected group, and the result then lands in the wrong register. A wrong state register shows up within one cycle, either as a missing or doubled start pulse or as `busy_o` staying high after the run flag drops. A faulty write path is caught in the cycle after each done strobe by reading back the channel just written. It is also caught in the same cycle as the strobe, where the old value must still be visible.

// File: rtl/sweep_adc_pkg.sv
`timescale 1ns/1ps
package sweep_adc_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_LAUNCH = 2'd1,
      SEQ_WAIT   = 2'd2
   } seq_state_e;

   // Highest channel of group g: groups grow two channels at a time,
   // clamped to the last physical channel.
   function automatic int unsigned group_last(input int unsigned grp,
                                              input int unsigned nch);
      int unsigned l;
      l = 2 * grp + 1;
      if (l > nch - 1) l = nch - 1;
      return l;
   endfunction

endpackage

// File: rtl/sweep_seq_ctrl.sv
`timescale 1ns/1ps
module sweep_seq_ctrl
   import sweep_adc_pkg::*;
#(
   parameter int unsigned NCH   = 8,
   parameter int unsigned CH_W  = 3,
   parameter int unsigned GRP_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [GRP_W-1:0] grp_i,
   input  logic             conv_done_i,
   output logic             launch_o,
   output logic             busy_o,
   output logic [CH_W-1:0]  chan_o,
   output logic             wr_en_o
);

   seq_state_e      state_q, state_d;
   logic [CH_W-1:0] chan_q, chan_d;
   logic [CH_W-1:0] last_ch;
   logic [CH_W-1:0] chan_inc;

   assign last_ch  = CH_W'(group_last(32'(grp_i), NCH));
   assign chan_inc = chan_q + CH_W'(1);

   always_comb begin
      state_d = state_q;
      chan_d  = chan_q;
      wr_en_o = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (run_i) begin
               state_d = SEQ_LAUNCH;
               chan_d  = '0;
            end
         end
         SEQ_LAUNCH: begin
            if (run_i) begin
               state_d = SEQ_WAIT;
            end else begin
               state_d = SEQ_IDLE;
               chan_d  = '0;
            end
         end
         SEQ_WAIT: begin
            if (!run_i) begin
               state_d = SEQ_IDLE;
               chan_d  = '0;
            end else if (conv_done_i) begin
               wr_en_o = 1'b1;
               state_d = SEQ_LAUNCH;
               chan_d  = (chan_q >= last_ch) ? '0 : chan_inc;
            end
         end
         default: begin
            state_d = SEQ_IDLE;
            chan_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         chan_q  <= '0;
      end else begin
         state_q <= state_d;
         chan_q  <= chan_d;
      end
   end

   assign launch_o = (state_q == SEQ_LAUNCH);
   assign busy_o   = (state_q != SEQ_IDLE);
   assign chan_o   = chan_q;

endmodule

// File: rtl/sweep_res_fmt.sv
`timescale 1ns/1ps
module sweep_res_fmt #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned LOW_W  = 2
) (
   input  logic              narrow_i,
   input  logic [DATA_W-1:0] raw_i,
   output logic [DATA_W-1:0] word_o
);

   assign word_o = narrow_i ? {raw_i[DATA_W-1:LOW_W], {LOW_W{1'b0}}} : raw_i;

endmodule

// File: rtl/sweep_res_file.sv
`timescale 1ns/1ps
module sweep_res_file #(
   parameter int unsigned NCH    = 8,
   parameter int unsigned DATA_W = 10,
   parameter int unsigned CH_W   = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [CH_W-1:0]   wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [CH_W-1:0]   rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] slots [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            q <= '0;
         else if (wr_en_i && (wr_idx_i == CH_W'(g)))
            q <= wr_data_i;
      end
      assign slots[g] = q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_idx_i == CH_W'(i)) rd_data_o = slots[i];
      end
   end

endmodule

// File: rtl/sweep_adc_seq.sv
`timescale 1ns/1ps
module sweep_adc_seq #(
   parameter  int unsigned NCH    = 8,
   parameter  int unsigned DATA_W = 10,
   parameter  int unsigned LOW_W  = 2,
   localparam int unsigned CH_W   = $clog2(NCH),
   localparam int unsigned GRP_W  = (NCH > 2) ? $clog2(NCH / 2) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [GRP_W-1:0]  grp_sel_i,
   input  logic              res8_i,
   output logic              conv_start_o,
   input  logic              conv_done_i,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic [CH_W-1:0]   chan_o,
   output logic              busy_o,
   input  logic [CH_W-1:0]   rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   if (NCH < 2 || (NCH % 2) != 0) begin : g_bad_nch
      $error("sweep_adc_seq: NCH must be even and at least 2");
   end
   if (LOW_W < 1 || LOW_W >= DATA_W) begin : g_bad_low
      $error("sweep_adc_seq: LOW_W must lie in 1..DATA_W-1");
   end

   logic              wr_en;
   logic [DATA_W-1:0] word;

   sweep_seq_ctrl #(
      .NCH   (NCH),
      .CH_W  (CH_W),
      .GRP_W (GRP_W)
   ) ctrl_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_i),
      .grp_i       (grp_sel_i),
      .conv_done_i (conv_done_i),
      .launch_o    (conv_start_o),
      .busy_o      (busy_o),
      .chan_o      (chan_o),
      .wr_en_o     (wr_en)
   );

   sweep_res_fmt #(
      .DATA_W (DATA_W),
      .LOW_W  (LOW_W)
   ) fmt_i (
      .narrow_i (res8_i),
      .raw_i    (conv_data_i),
      .word_o   (word)
   );

   sweep_res_file #(
      .NCH    (NCH),
      .DATA_W (DATA_W),
      .CH_W   (CH_W)
   ) file_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (chan_o),
      .wr_data_i (word),
      .rd_idx_i  (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

endmodule

// File: rtl/sweep_adc_seq_chk.sv
`timescale 1ns/1ps
module sweep_adc_seq_chk #(
   parameter  int unsigned NCH    = 8,
   parameter  int unsigned DATA_W = 10,
   parameter  int unsigned LOW_W  = 2,
   localparam int unsigned CH_W   = $clog2(NCH),
   localparam int unsigned GRP_W  = (NCH > 2) ? $clog2(NCH / 2) : 1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              run_i,
   input logic [GRP_W-1:0]  grp_sel_i,
   input logic              res8_i,
   input logic              conv_start_o,
   input logic              conv_done_i,
   input logic [DATA_W-1:0] conv_data_i,
   input logic [CH_W-1:0]   chan_o,
   input logic              busy_o,
   input logic [CH_W-1:0]   rd_addr_i,
   input logic [DATA_W-1:0] rd_data_o
);

   logic              waiting;
   logic              accept;
   logic [CH_W-1:0]   exp_next;
   logic [DATA_W-1:0] exp_word;
   int unsigned       top_ch;

   assign waiting  = busy_o && !conv_start_o;
   assign accept   = waiting && run_i && conv_done_i;
   assign top_ch   = sweep_adc_pkg::group_last(32'(grp_sel_i), NCH);
   assign exp_next = (32'(chan_o) >= top_ch) ? '0 : CH_W'(32'(chan_o) + 1);
   assign exp_word = res8_i ? (conv_data_i & ({DATA_W{1'b1}} << LOW_W)) : conv_data_i;

   // R2
   launch_ch0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && run_i) |=> (conv_start_o && chan_o == '0));

   // R3
   single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_start_o |=> !conv_start_o);

   // R3
   wait_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waiting && !conv_done_i) |=> !conv_start_o);

   // R6
   next_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (conv_start_o && chan_o == $past(exp_next)));

   // R7
   stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !run_i) |=> (!busy_o && chan_o == '0));

   // R8
   stored_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && rd_addr_i == chan_o) |=>
         (!$stable(rd_addr_i) || rd_data_o == $past(exp_word)));

   // R10
   quiet_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!accept) |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));

endmodule

bind sweep_adc_seq sweep_adc_seq_chk #(
   .NCH    (NCH),
   .DATA_W (DATA_W),
   .LOW_W  (LOW_W)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .run_i        (run_i),
   .grp_sel_i    (grp_sel_i),
   .res8_i       (res8_i),
   .conv_start_o (conv_start_o),
   .conv_done_i  (conv_done_i),
   .conv_data_i  (conv_data_i),
   .chan_o       (chan_o),
   .busy_o       (busy_o),
   .rd_addr_i    (rd_addr_i),
   .rd_data_o    (rd_data_o)
);

// File: tb/sweep_adc_seq_tb_top.sv
`timescale 1ns/1ps
module sweep_adc_seq_tb_top;

   logic       clk     = 1'b0;
   logic       rst_n   = 1'b0;
   logic       run     = 1'b0;
   logic       narrow  = 1'b0;
   logic       done    = 1'b0;
   logic [1:0] grp     = 2'd0;
   logic [9:0] data    = '0;
   logic [2:0] rd_addr = '0;
   logic       conv_start, busy;
   logic [2:0] chan;
   logic [9:0] rd_data;

   int         n_cmp = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;
   logic [2:0] exp_q [$];
   logic [9:0] exp_reg [8];

   always #2.5 clk = ~clk;

   sweep_adc_seq dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .run_i        (run),
      .grp_sel_i    (grp),
      .res8_i       (narrow),
      .conv_start_o (conv_start),
      .conv_done_i  (done),
      .conv_data_i  (data),
      .chan_o       (chan),
      .busy_o       (busy),
      .rd_addr_i    (rd_addr),
      .rd_data_o    (rd_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Monitor: every launch must match the next expected channel (R2 R5 R6)
   always @(negedge clk) begin
      if (rst_n && conv_start) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected launch on channel", int'(chan), -1);
         end else begin
            chk(chan == exp_q[0], "R5 R6 R2", "launch channel order",
                int'(chan), int'(exp_q[0]));
            void'(exp_q.pop_front());
         end
      end
   end

   task automatic read_all(input string req);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rd_addr = 3'(i);
         #1;
         chk(rd_data == exp_reg[i], req, "register readback", int'(rd_data), int'(exp_reg[i]));
      end
   endtask

   // Driver: pushes the expected launch order, plays the conversion engine
   task automatic run_sweep(input logic [1:0] g, input bit nar, input int n);
      int last;
      int ch;
      last = 2 * int'(g) + 1;
      ch = 0;
      for (int k = 0; k <= n; k++) begin
         exp_q.push_back(3'(ch));
         ch = (ch == last) ? 0 : ch + 1;
      end
      ch = 0;
      @(negedge clk);
      grp = g; narrow = nar; run = 1'b1;
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         while (!conv_start) @(negedge clk);
         for (int w = 0; w < 1 + (k % 3); w++) begin
            @(negedge clk);
            chk(!conv_start, "R3", "launch before done", int'(conv_start), 0);
         end
         data    = 10'(37 * k + 101 * ch + 13 * int'(g) + 3);
         rd_addr = 3'(ch);
         done    = 1'b1;
         #1;
         chk(rd_data == exp_reg[ch], "R9", "old value in write cycle",
             int'(rd_data), int'(exp_reg[ch]));
         exp_reg[ch] = nar ? {data[9:2], 2'b00} : data;
         @(negedge clk);
         done = 1'b0;
         #1;
         chk(rd_data == exp_reg[ch], nar ? "R8" : "R4", "stored result",
             int'(rd_data), int'(exp_reg[ch]));
         ch = (ch == last) ? 0 : ch + 1;
      end
      while (!conv_start) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk(!busy, "R7", "busy after stop", int'(busy), 0);
      chk(chan == 3'd0, "R7", "channel after stop", int'(chan), 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) exp_reg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(!busy, "R1", "busy after reset", int'(busy), 0);
      chk(!conv_start, "R1", "launch after reset", int'(conv_start), 0);
      chk(chan == 3'd0, "R1", "channel after reset", int'(chan), 0);
      read_all("R1");

      run_sweep(2'd0, 1'b0, 5);   // two-channel group, wraps twice
      run_sweep(2'd1, 1'b1, 6);   // four channels, reduced resolution
      run_sweep(2'd2, 1'b0, 8);   // six channels
      run_sweep(2'd3, 1'b0, 11);  // eight channels
      run_sweep(2'd3, 1'b1, 9);   // eight channels, reduced resolution
      read_all("R4");

      // R7 abandon mid-conversion, late done must not write
      exp_q.push_back(3'd0);
      @(negedge clk);
      grp = 2'd3; narrow = 1'b0; run = 1'b1;
      @(negedge clk);
      while (!conv_start) @(negedge clk);
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk(!busy, "R7", "busy after abandon", int'(busy), 0);
      data = 10'd777; done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      rd_addr = 3'd0;
      #1;
      chk(rd_data == exp_reg[0], "R7", "abandoned result written", int'(rd_data), int'(exp_reg[0]));

      // R10 done while idle
      repeat (2) @(negedge clk);
      data = 10'd555; done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      @(negedge clk);
      chk(!busy, "R10", "busy after idle done", int'(busy), 0);
      read_all("R10");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "launches missing", exp_q.size(), 0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R3 watchdog: actual 0 expected 1 (run completed)");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule